// File: doc/BRIEF.md
# Segmented Bus Repeater Switch

The block is a programmable junction placed between bus segments. On each of its two sides it meets two segments: a local one and an express one. That gives four segments, numbered 0 = local side A, 1 = express side A, 2 = local side B and 3 = express side B. A 5-bit function code picks one of twenty-one connection functions. Each function names one source segment and the set of segments that source drives. Every driven path regenerates the signal through a register, so a path runs one way only.

The function set looks the same when the two sides are swapped, and when the two bus types are swapped. It contains four groups:
- isolation;
- a single path from one segment to one other segment;
- a path from one segment to both segments of the opposite side;
- a broadcast from one segment to all three others.

A build-time option adds a pass mode for long tri-state buses. This mode joins the two local segments only, and a direction-sense input chooses which local side drives the other.

Top module: `seg_repeater`

## Requirements
- R1: While `rst` is high at a rising edge, every `seg_oe` bit and every `seg_out` bit is 0 after that edge.
- R2: Code 0 (isolate) asserts no output enable.
- R3: Codes 1..12 drive a single path. With k = code-1, the source is s = k/3. The destination is j = k%3 when j < s, and j+1 otherwise. Only the destination's enable is set.
- R4: Codes 13..16 use source s = code-13. That source drives both segments of the other side: segments 2 and 3 when s < 2, and segments 0 and 1 otherwise.
- R5: Codes 17..20 use source s = code-17. That source drives all three other segments.
- R6: Codes 21..31 behave as isolate: no enable is asserted.
- R7: Each enabled output equals the source segment's input sampled at the previous rising edge (one cycle of latency). A disabled output reads 0.
- R8: A source segment never has its own enable asserted, so every path is one way.
- R9: With the pass option built in (`BIDIR_EN`=1) and `pass_mode`=1, the function code is overridden. `pass_dir`=0 drives segment 2 from segment 0. `pass_dir`=1 drives segment 0 from segment 2.
- R10: With the pass option left out (`BIDIR_EN`=0), `pass_mode` and `pass_dir` have no effect, and the function code alone selects the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_code | input | 5 | Connection function code |
| pass_mode | input | 1 | Request for local-to-local pass mode |
| pass_dir | input | 1 | Pass direction: 0 = side A drives side B, 1 = side B drives side A |
| seg_in | input | 4*W | Segment inputs; segment i occupies bits [i*W +: W] |
| seg_out | output | 4*W | Regenerated segment outputs, in the same layout |
| seg_oe | output | 4 | Output enable for each segment |

## Verification
A wrong decode shows up one cycle after the code is applied. It appears as a wrong count or wrong position of enable bits, or as an enable on the source segment itself. A wrong source selection shows up in the same cycle as a data value that matches another segment's input. Because every segment carries a distinct value, each misrouting can be told apart.

A lane register that is stuck, or that fails to clear, leaves a nonzero value on a disabled output. That fault is visible from the first cycle after the enable drops.

// File: rtl/seg_repeater_pkg.sv
package seg_repeater_pkg;

    localparam int NSEG      = 4;
    localparam int CODE_W    = 5;
    localparam int LAST_CODE = 20;

    typedef logic [1:0] seg_idx_t;

    typedef struct packed {
        seg_idx_t          src;
        logic [NSEG-1:0]   dmask;
    } route_t;

    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_SINGLE,
        GRP_SIDE,
        GRP_ALL
    } fn_group_t;

    function automatic fn_group_t group_of(logic [CODE_W-1:0] code);
        if (code == 0 || int'(code) > LAST_CODE) return GRP_NONE;
        else if (code <= 5'd12)                  return GRP_SINGLE;
        else if (code <= 5'd16)                  return GRP_SIDE;
        else                                     return GRP_ALL;
    endfunction

    function automatic logic [NSEG-1:0] onehot(seg_idx_t i);
        return NSEG'(1) << i;
    endfunction

    function automatic route_t decode(logic [CODE_W-1:0] code,
                                      logic pmode, logic pdir, bit pass_ok);
        route_t        r;
        logic [4:0]    k;
        seg_idx_t      s;
        seg_idx_t      j;
        r.src   = '0;
        r.dmask = '0;
        k       = '0;
        s       = '0;
        j       = '0;
        if (pass_ok && pmode) begin
            r.src   = pdir ? seg_idx_t'(2) : seg_idx_t'(0);
            r.dmask = pdir ? onehot(2'd0) : onehot(2'd2);
        end else begin
            unique case (group_of(code))
                GRP_SINGLE: begin
                    k     = code - 5'd1;
                    s     = seg_idx_t'(k / 5'd3);
                    j     = seg_idx_t'(k % 5'd3);
                    r.src = s;
                    r.dmask = onehot((j < s) ? j : j + 2'd1);
                end
                GRP_SIDE: begin
                    k       = code - 5'd13;
                    r.src   = seg_idx_t'(k);
                    r.dmask = k[1] ? 4'b0011 : 4'b1100;
                end
                GRP_ALL: begin
                    k       = code - 5'd17;
                    r.src   = seg_idx_t'(k);
                    r.dmask = ~onehot(seg_idx_t'(k));
                end
                default: begin
                    r.src   = '0;
                    r.dmask = '0;
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/seg_repeater_decode.sv
module seg_repeater_decode
    import seg_repeater_pkg::*;
#(
    parameter bit BIDIR_EN = 1'b1
) (
    input  logic [CODE_W-1:0] fn_code,
    input  logic              pass_mode,
    input  logic              pass_dir,
    output route_t            route
);
    always_comb begin
        route = decode(fn_code, pass_mode, pass_dir, BIDIR_EN);
    end
endmodule

// File: rtl/seg_repeater_lane.sv
module seg_repeater_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         drive,
    input  logic [W-1:0] src_val,
    output logic [W-1:0] out_q,
    output logic         oe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= 1'b0;
        end else begin
            out_q <= drive ? src_val : '0;
            oe_q  <= drive;
        end
    end
endmodule

// File: rtl/seg_repeater.sv
module seg_repeater
    import seg_repeater_pkg::*;
#(
    parameter int W        = 8,
    parameter bit BIDIR_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W-1:0]   fn_code,
    input  logic                pass_mode,
    input  logic                pass_dir,
    input  logic [NSEG*W-1:0]   seg_in,
    output logic [NSEG*W-1:0]   seg_out,
    output logic [NSEG-1:0]     seg_oe
);
    route_t       route;
    logic [W-1:0] seg_arr [NSEG];
    logic [W-1:0] src_val;

    seg_repeater_decode #(.BIDIR_EN(BIDIR_EN)) u_dec (
        .fn_code   (fn_code),
        .pass_mode (pass_mode),
        .pass_dir  (pass_dir),
        .route     (route)
    );

    always_comb begin
        for (int i = 0; i < NSEG; i++) seg_arr[i] = seg_in[i*W +: W];
        src_val = seg_arr[route.src];
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_lane
        seg_repeater_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .drive   (route.dmask[g]),
            .src_val (src_val),
            .out_q   (seg_out[g*W +: W]),
            .oe_q    (seg_oe[g])
        );
    end
endmodule

// File: rtl/seg_repeater_chk.sv
module seg_repeater_chk
    import seg_repeater_pkg::*;
#(
    parameter int W        = 8,
    parameter bit BIDIR_EN = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic [CODE_W-1:0]   fn_code,
    input logic                pass_mode,
    input logic                pass_dir,
    input logic [NSEG*W-1:0]   seg_out,
    input logic [NSEG-1:0]     seg_oe
);
    logic [NSEG*W-1:0] oe_wide;
    logic              passing;

    always_comb begin
        for (int i = 0; i < NSEG; i++) oe_wide[i*W +: W] = {W{seg_oe[i]}};
        passing = pass_mode && BIDIR_EN;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (seg_oe == '0 && seg_out == '0));

    a_r2_isolate: assert property (@(posedge clk) disable iff (rst)
        (!passing && fn_code == 5'd0) |=> seg_oe == '0);

    a_r3_single_path: assert property (@(posedge clk) disable iff (rst)
        (!passing && fn_code >= 5'd1 && fn_code <= 5'd12) |=> $countones(seg_oe) == 1);

    a_r4_side_pair: assert property (@(posedge clk) disable iff (rst)
        (!passing && fn_code >= 5'd13 && fn_code <= 5'd16) |=> $countones(seg_oe) == 2);

    a_r5_broadcast: assert property (@(posedge clk) disable iff (rst)
        (!passing && fn_code >= 5'd17 && fn_code <= 5'd20) |=> $countones(seg_oe) == 3);

    a_r6_illegal_isolate: assert property (@(posedge clk) disable iff (rst)
        (!passing && fn_code >= 5'd21) |=> seg_oe == '0);

    a_r7_disabled_zero: assert property (@(posedge clk) disable iff (rst)
        (seg_out & ~oe_wide) == '0);

    a_r9_pass_dir: assert property (@(posedge clk) disable iff (rst)
        passing |=> seg_oe == ($past(pass_dir) ? 4'b0001 : 4'b0100));
endmodule

bind seg_repeater seg_repeater_chk #(.W(W), .BIDIR_EN(BIDIR_EN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fn_code   (fn_code),
    .pass_mode (pass_mode),
    .pass_dir  (pass_dir),
    .seg_out   (seg_out),
    .seg_oe    (seg_oe)
);

// File: tb/seg_repeater_test.sv
`timescale 1ns/100ps
module seg_repeater_test;
    localparam int W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [4:0]      fn_code = '0;
    logic            pass_mode = 1'b0;
    logic            pass_dir = 1'b0;
    logic [4*W-1:0]  seg_in = '0;
    logic [4*W-1:0]  out_a, out_b;
    logic [3:0]      oe_a, oe_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    seg_repeater #(.W(W), .BIDIR_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .fn_code(fn_code), .pass_mode(pass_mode),
        .pass_dir(pass_dir), .seg_in(seg_in), .seg_out(out_a), .seg_oe(oe_a));

    seg_repeater #(.W(W), .BIDIR_EN(1'b0)) uut_nb (
        .clk(clk), .rst(rst), .fn_code(fn_code), .pass_mode(pass_mode),
        .pass_dir(pass_dir), .seg_in(seg_in), .seg_out(out_b), .seg_oe(oe_b));

    function automatic logic [W-1:0] pat(int p, int i);
        return W'(p * 53 + i * 29 + 11);
    endfunction

    function automatic string tag_of(int c, bit pm);
        if (pm)                  return "R9";
        if (c == 0)              return "R2";
        if (c <= 12)             return "R3";
        if (c <= 16)             return "R4";
        if (c <= 20)             return "R5";
        return "R6";
    endfunction

    // expected source and destination mask from the requirement text
    task automatic expect_route(input int c, input bit pm, input bit pd,
                                input bit pass_ok, output int s, output logic [3:0] m);
        s = 0;
        m = 4'b0000;
        if (pass_ok && pm) begin
            s = pd ? 2 : 0;
            m = pd ? 4'b0001 : 4'b0100;
        end else if (c >= 1 && c <= 12) begin
            int j;
            s = (c - 1) / 3;
            j = (c - 1) % 3;
            m[(j < s) ? j : j + 1] = 1'b1;
        end else if (c >= 13 && c <= 16) begin
            s = c - 13;
            m = (s < 2) ? 4'b1100 : 4'b0011;
        end else if (c >= 17 && c <= 20) begin
            s = c - 17;
            m = 4'b1111;
            m[s] = 1'b0;
        end
    endtask

    task automatic check(input string tag, input string who,
                         input logic [4*W-1:0] got_o, input logic [3:0] got_e,
                         input logic [4*W-1:0] exp_o, input logic [3:0] exp_e);
        n_checks++;
        if (got_o !== exp_o || got_e !== exp_e) begin
            n_fail++;
            $display("FAIL %s %s: out=%h oe=%b expected out=%h oe=%b",
                     tag, who, got_o, got_e, exp_o, exp_e);
        end
    endtask

    task automatic run(input int c, input bit pm, input bit pd, input int p);
        int s_a, s_b;
        logic [3:0] m_a, m_b;
        logic [4*W-1:0] eo_a, eo_b;
        @(negedge clk);
        fn_code   = 5'(c);
        pass_mode = pm;
        pass_dir  = pd;
        for (int i = 0; i < 4; i++) seg_in[i*W +: W] = pat(p, i);
        expect_route(c, pm, pd, 1'b1, s_a, m_a);
        expect_route(c, pm, pd, 1'b0, s_b, m_b);
        for (int i = 0; i < 4; i++) begin
            eo_a[i*W +: W] = m_a[i] ? pat(p, s_a) : '0;
            eo_b[i*W +: W] = m_b[i] ? pat(p, s_b) : '0;
        end
        @(posedge clk);
        #1;
        // R7: one-cycle latency, source value on enabled lanes; R8: no self-drive
        check(tag_of(c, pm), "R7 uut", out_a, oe_a, eo_a, m_a);
        check(pm ? "R10" : tag_of(c, pm), "R8 uut_nb", out_b, oe_b, eo_b, m_b);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset uut", out_a, oe_a, '0, 4'b0000);
        check("R1", "reset uut_nb", out_b, oe_b, '0, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 3; p++)
            for (int c = 0; c < 32; c++)
                run(c, 1'b0, 1'b0, p);
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 32; c += 3) begin
                run(c, 1'b1, 1'b0, p);
                run(c, 1'b1, 1'b1, p);
            end
        // back-to-back changes: enable must drop to zero after broadcast
        run(17, 1'b0, 1'b0, 1);
        run(0, 1'b0, 1'b0, 2);
        run(20, 1'b0, 1'b0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "mid-run reset uut", out_a, oe_a, '0, 4'b0000);
        check("R1", "mid-run reset uut_nb", out_b, oe_b, '0, 4'b0000);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule